// File: doc/BRIEF.md
# Index-Register Address Modifier

This block computes the effective operand address for an instruction. It takes the instruction's 15-bit address field and a 3-bit tag field. The tag chooses which of seven 15-bit index registers to use. The block subtracts the chosen index value from the address, modulo 2^15. It does this by adding the two's complement of the index value in one shared 15-bit adder.

A one-bit mode flag chooses how the tag is read:

- **Normal mode:** a non-zero tag names one register.
- **Compatibility mode:** each tag bit enables one of three registers, and the enabled registers are ORed together. Bit 0 enables register 1, bit 1 enables register 2 and bit 2 enables register 4.

Index registers are loaded through the same adder. A load takes the adder for one cycle, and the effective-address output is marked invalid during that cycle. A read port shows the contents of any register. The effective address is combinational in the current register and mode state. Register writes and mode changes take effect at the rising clock edge.

Top module: `xr_addr_mod`

## Requirements
- R1: While `rst` is high at a rising edge, all seven index registers clear to zero and the mode flag clears to 0 (normal mode).
- R2: In normal mode (`mt_mode`=0), with `wr_en` low and `tag` in 1..7, `ea` equals (`addr` - XR[`tag`]) mod 2^15.
- R3: With `tag`=0 and `wr_en` low, `ea` equals `addr` in either mode.
- R4: In compatibility mode (`mt_mode`=1), with `wr_en` low, the subtracted value is the bitwise OR of the enabled registers. Tag bit 0 enables XR1, bit 1 enables XR2 and bit 2 enables XR4. `ea` = (`addr` - OR) mod 2^15.
- R5: `mt_clr` high clears the mode flag at the next edge. Otherwise `mt_set` high sets it. With both low, the flag holds its value.
- R6: With `wr_en` high and `wr_sel` in 1..7, XR[`wr_sel`] takes `wr_data` at the rising edge.
- R7: A write with `wr_sel`=0 changes no register.
- R8: `ea_vld` is low in every cycle with `wr_en` high and high otherwise.
- R9: `rd_data` shows XR[`rd_sel`] for `rd_sel` in 1..7, and shows 0 for `rd_sel`=0.
- R10: `wr_sel` names a register directly in both modes, so a write in compatibility mode can reach registers 3, 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mt_set | input | 1 | Enter compatibility (OR-combining) tag mode |
| mt_clr | input | 1 | Return to normal tag mode; wins over `mt_set` |
| addr | input | 15 | Instruction address field |
| tag | input | 3 | Instruction tag field |
| wr_en | input | 1 | Load an index register through the adder |
| wr_sel | input | 3 | Register number to load (0 = none) |
| wr_data | input | 15 | Value to load |
| rd_sel | input | 3 | Register number shown on `rd_data` |
| rd_data | output | 15 | Contents of the selected register |
| ea | output | 15 | Effective address |
| ea_vld | output | 1 | `ea` is meaningful (adder not busy with a load) |
| mt_mode | output | 1 | Current tag mode (1 = compatibility) |

## Verification
The assertions check several properties on every cycle:

- Registers that are not addressed keep their value across an edge.
- An addressed register takes the written value.
- The mode flag follows its set and clear inputs.
- Adding the selected index value back to a valid effective address recovers the address field.
- In compatibility mode, the subtracted value never carries a bit that none of registers 1, 2 and 4 holds.

Other behaviour can only be shown by the bench's scenarios against its reference model:

- that the right register is picked for each tag;
- the exact OR combination for every tag subset;
- a zero tag passing the address through, and the wrap at 2^15;
- writes in compatibility mode reaching registers 3, 5, 6 and 7.

// File: rtl/xr_pkg.sv
package xr_pkg;
    localparam int XW = 15;
    localparam int DEF_NXR = 7;

    typedef enum logic {
        ADD_MODIFY = 1'b0,
        ADD_LOAD   = 1'b1
    } add_op_e;

    typedef struct packed {
        logic [XW-1:0] opa;
        logic [XW-1:0] opb;
        logic          cin;
    } add_in_t;

    function automatic add_in_t build_add(add_op_e op, logic [XW-1:0] addr_f,
                                          logic [XW-1:0] idx, logic [XW-1:0] ld);
        add_in_t r;
        if (op == ADD_LOAD) begin
            r.opa = ld;
            r.opb = '0;
            r.cin = 1'b0;
        end else begin
            r.opa = addr_f;
            r.opb = ~idx;
            r.cin = 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/xr_file.sv
module xr_file
    import xr_pkg::*;
#(
    parameter int NXR = DEF_NXR,
    localparam int TW = $clog2(NXR + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [TW-1:0] wr_sel,
    input  logic [XW-1:0] wr_val,
    input  logic [TW-1:0] rd_sel,
    output logic [XW-1:0] rd_val,
    output logic [XW-1:0] regs [NXR]
);
    for (genvar i = 0; i < NXR; i++) begin : g_reg
        localparam logic [TW-1:0] MYSEL = TW'(i + 1);

        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (wr_en && wr_sel == MYSEL)
                regs[i] <= wr_val;
        end

        assert_keep_R7: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_sel == MYSEL) |=> $stable(regs[i]));

        assert_load_R6: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel == MYSEL) |=> regs[i] == $past(wr_val));
    end

    always_comb begin
        rd_val = '0;
        for (int k = 0; k < NXR; k++)
            if (rd_sel == TW'(k + 1))
                rd_val = regs[k];
    end
endmodule

// File: rtl/xr_tag_decode.sv
module xr_tag_decode
    import xr_pkg::*;
#(
    parameter int NXR = DEF_NXR,
    localparam int TW = $clog2(NXR + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mt_mode,
    input  logic [TW-1:0] tag,
    input  logic [XW-1:0] regs [NXR],
    output logic [XW-1:0] idx
);
    logic [XW-1:0] one_sel;
    logic [XW-1:0] or_terms [TW];
    logic [XW-1:0] or_sel;
    logic [XW-1:0] reach;

    always_comb begin
        one_sel = '0;
        for (int k = 0; k < NXR; k++)
            if (tag == TW'(k + 1))
                one_sel = regs[k];
    end

    for (genvar b = 0; b < TW; b++) begin : g_bit
        if ((1 << b) <= NXR) begin : g_on
            assign or_terms[b] = tag[b] ? regs[(1 << b) - 1] : '0;
        end else begin : g_off
            assign or_terms[b] = '0;
        end
    end

    always_comb begin
        or_sel = '0;
        reach  = '0;
        for (int b = 0; b < TW; b++) begin
            or_sel = or_sel | or_terms[b];
            if ((1 << b) <= NXR)
                reach = reach | regs[(1 << b) - 1];
        end
    end

    assign idx = mt_mode ? or_sel : one_sel;

    assert_mt_reach_R4: assert property (@(posedge clk) disable iff (rst)
        mt_mode |-> (idx & ~reach) == '0);
endmodule

// File: rtl/xr_adder.sv
module xr_adder
    import xr_pkg::*;
(
    input  add_in_t       op,
    output logic [XW-1:0] sum
);
    logic [XW:0] full;
    assign full = {1'b0, op.opa} + {1'b0, op.opb} + {{XW{1'b0}}, op.cin};
    assign sum  = full[XW-1:0];
endmodule

// File: rtl/xr_addr_mod.sv
module xr_addr_mod
    import xr_pkg::*;
#(
    parameter int NXR = DEF_NXR,
    localparam int TW = $clog2(NXR + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mt_set,
    input  logic          mt_clr,
    input  logic [XW-1:0] addr,
    input  logic [TW-1:0] tag,
    input  logic          wr_en,
    input  logic [TW-1:0] wr_sel,
    input  logic [XW-1:0] wr_data,
    input  logic [TW-1:0] rd_sel,
    output logic [XW-1:0] rd_data,
    output logic [XW-1:0] ea,
    output logic          ea_vld,
    output logic          mt_mode
);
    logic [XW-1:0] regs [NXR];
    logic [XW-1:0] idx;
    logic [XW-1:0] sum;
    add_op_e       op;
    add_in_t       add_in;

    always_ff @(posedge clk) begin
        if (rst)         mt_mode <= 1'b0;
        else if (mt_clr) mt_mode <= 1'b0;
        else if (mt_set) mt_mode <= 1'b1;
    end

    xr_tag_decode #(.NXR(NXR)) u_dec (
        .clk(clk), .rst(rst), .mt_mode(mt_mode), .tag(tag),
        .regs(regs), .idx(idx)
    );

    assign op     = wr_en ? ADD_LOAD : ADD_MODIFY;
    assign add_in = build_add(op, addr, idx, wr_data);

    xr_adder u_add (.op(add_in), .sum(sum));

    xr_file #(.NXR(NXR)) u_file (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(sum),
        .rd_sel(rd_sel), .rd_val(rd_data), .regs(regs)
    );

    assign ea     = sum;
    assign ea_vld = (op == ADD_MODIFY);

    assert_undo_R2: assert property (@(posedge clk) disable iff (rst)
        ea_vld |-> XW'(ea + idx) == addr);

    assert_pass_R3: assert property (@(posedge clk) disable iff (rst)
        (ea_vld && tag == '0) |-> ea == addr);

    assert_clr_R5: assert property (@(posedge clk) disable iff (rst)
        mt_clr |=> !mt_mode);

    assert_set_R5: assert property (@(posedge clk) disable iff (rst)
        (mt_set && !mt_clr) |=> mt_mode);

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!mt_set && !mt_clr) |=> $stable(mt_mode));
endmodule

// File: tb/xr_addr_mod_tb.sv
module xr_addr_mod_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic        mt_set = 0, mt_clr = 0, wr_en = 0;
    logic [14:0] addr = 0, wr_data = 0;
    logic [2:0]  tag = 0, wr_sel = 0, rd_sel = 0;
    logic [14:0] rd_data, ea;
    logic        ea_vld, mt_mode;

    int checks = 0;
    int errors = 0;
    logic [14:0] mxr [8];
    logic        mmode;

    always #2 clk = ~clk;

    xr_addr_mod u_dut (
        .clk(clk), .rst(rst), .mt_set(mt_set), .mt_clr(mt_clr), .addr(addr),
        .tag(tag), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .ea(ea), .ea_vld(ea_vld),
        .mt_mode(mt_mode)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] model_idx(logic [2:0] t);
        logic [14:0] v = 0;
        if (mmode) begin
            if (t[0]) v |= mxr[1];
            if (t[1]) v |= mxr[2];
            if (t[2]) v |= mxr[4];
        end else if (t != 0) begin
            v = mxr[t];
        end
        return v;
    endfunction

    task automatic step(input logic [2:0] t, input logic [14:0] a, input bit we,
                        input logic [2:0] ws, input logic [14:0] wd, input bit s,
                        input bit c, input logic [2:0] rs);
        logic [14:0] exp_ea;
        string req;
        @(negedge clk);
        tag = t; addr = a; wr_en = we; wr_sel = ws; wr_data = wd;
        mt_set = s; mt_clr = c; rd_sel = rs;
        #1;
        check(ea_vld == !we, "R8 ea_vld", ea_vld, !we);
        if (!we) begin
            exp_ea = a - model_idx(t);
            req = (t == 0) ? "R3 pass-through" : (mmode ? "R4 or-combine" : "R2 single-select");
            check(ea == exp_ea, req, ea, exp_ea);
        end
        check(rd_data == (rs == 0 ? 15'd0 : mxr[rs]), "R9 R6 R7 R10 register contents",
              rd_data, rs == 0 ? 0 : mxr[rs]);
        check(mt_mode == mmode, "R5 mode flag", mt_mode, mmode);
        if (we && ws != 0) mxr[ws] = wd;
        if (c) mmode = 0; else if (s) mmode = 1;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mxr[i] = 0;
        mmode = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1: reset state
        #1;
        check(mt_mode == 0, "R1 mode after reset", mt_mode, 0);
        for (int r = 1; r < 8; r++) begin
            rd_sel = 3'(r); #0.1;
            check(rd_data == 0, "R1 register after reset", rd_data, 0);
        end
        // R6: load each register
        for (int r = 1; r < 8; r++)
            step(0, 0, 1, 3'(r), 15'(r * 15'h1111 + 3), 0, 0, 3'(r - 1));
        // R2 each tag in normal mode, plus wrap below zero
        for (int t = 0; t < 8; t++) step(3'(t), 15'h4000, 0, 0, 0, 0, 0, 3'(t));
        step(7, 15'h0001, 0, 0, 0, 0, 0, 7);
        // R5 enter compatibility mode; R4 every subset
        step(0, 15'h1234, 0, 0, 0, 1, 0, 1);
        for (int t = 0; t < 8; t++) step(3'(t), 15'h7FFF, 0, 0, 0, 0, 0, 4);
        // R10 writes to registers unreachable by tag in this mode
        step(0, 0, 1, 5, 15'h0A5A, 0, 0, 5);
        step(0, 0, 1, 7, 15'h7001, 0, 0, 5);
        step(7, 15'h0100, 0, 0, 0, 0, 0, 7);
        // R7 write with selector zero
        step(0, 0, 1, 0, 15'h7777, 0, 0, 0);
        for (int r = 0; r < 8; r++) step(3'(r), 15'h2222, 0, 0, 0, 0, 0, 3'(r));
        // R5 clear wins over set, then hold
        step(0, 0, 0, 0, 0, 1, 1, 0);
        step(3, 15'h0005, 0, 0, 0, 0, 0, 3);
        step(3, 15'h0005, 0, 0, 0, 0, 0, 3);
        // random traffic
        for (int n = 0; n < 3000; n++)
            step(3'($urandom), 15'($urandom), ($urandom % 4) == 0, 3'($urandom),
                 15'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0, 3'($urandom));
        // mid-run reset
        @(negedge clk); rst = 1; wr_en = 0; mt_set = 0; mt_clr = 0;
        @(negedge clk); rst = 0;
        for (int i = 0; i < 8; i++) mxr[i] = 0;
        mmode = 0;
        for (int r = 0; r < 8; r++) step(3'(r), 15'h0300, 0, 0, 0, 0, 0, 3'(r));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule